// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block turns a 31-bit data word into one 32-bit ARINC 429 serial word. It drives the line as three return-to-zero states: HI, LO or NULL. A host loads the data as two 16-bit half-words. The first half-word holds the label and the low data bits, and the second holds the upper data bits. A one-cycle start pulse then sends the word. The transmitter computes bit 32 as odd or even parity over bits 1 to 31. It sends ARINC bit 1 first. Each bit period drives HI or LO for its first half and NULL for its second half. After bit 32 the line stays NULL for a fixed gap. Busy stays high until that gap ends.

One control input sets the bit period to 10 or 80 master clocks. Another chooses the parity sense. A self-test input copies the serial line state onto a pair of loopback outputs that feed the receiver inputs. While self-test is low, those loopback outputs stay NULL.

Top module: `a429_tx_top`

## Requirements
- R1: The bit period is 10 master clocks when `rate_slow`=0 and 80 master clocks when `rate_slow`=1. Each half of a bit lasts half that long. `rate_slow` is sampled on the start cycle, and changes while a word is being sent have no effect on that word.
- R2: In the cycle after an accepted start, the line begins sending ARINC bit 1. Bits follow in ascending order up to bit 32. Each bit drives `line_hi` (bit = 1) or `line_lo` (bit = 0) for the first half-period and NULL (both low) for the second half-period.
- R3: A write with `wr_hw1` maps `wr_data` bits [15:11] to ARINC bits 13..9 and bits [7:0] to ARINC bits 1..8, with bit 7 going to ARINC bit 1. `wr_data` bit 10 goes to ARINC bit 31 and bit 9 to ARINC bit 30. `wr_data` bit 8, which is the bit 32 slot, is ignored. A write with `wr_hw2` maps `wr_data` bits [15:0] to ARINC bits 29..14.
- R4: With `par_even`=0, bit 32 makes the number of ones across all 32 bits odd. With `par_even`=1, it makes that number even. The parity sense is captured on the start cycle.
- R5: After bit 32 the line holds NULL for 4 bit times. `busy` is high from the cycle after an accepted start through the end of that gap, which is 72 half-periods in total. It is low at all other times.
- R6: A half-word write or a start pulse that arrives while `busy` is high has no effect. The stored data, the word in flight and the timing of the next word are all unchanged.
- R7: While `self_test`=1, `lb_hi`/`lb_lo` equal `line_hi`/`line_lo` in every cycle. While `self_test`=0, both loopback outputs are low.
- R8: After reset, `busy`, `line_hi`, `line_lo`, `lb_hi` and `lb_lo` are low, and the stored data is all zero.
- R9: `line_hi` and `line_lo` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_slow | input | 1 | 0: bit period of 10 clocks, 1: bit period of 80 clocks |
| par_even | input | 1 | 0: odd parity, 1: even parity |
| self_test | input | 1 | Routes the line state to the loopback outputs |
| wr_hw1 | input | 1 | Write strobe for half-word 1 |
| wr_hw2 | input | 1 | Write strobe for half-word 2 |
| wr_data | input | 16 | Half-word write data |
| start | input | 1 | One-cycle pulse that starts sending the stored word |
| line_hi | output | 1 | Line drive enable for the HI state |
| line_lo | output | 1 | Line drive enable for the LO state |
| busy | output | 1 | High while a word or its gap is in progress |
| lb_hi | output | 1 | Loopback HI toward the receiver |
| lb_lo | output | 1 | Loopback LO toward the receiver |

## Verification
A scoreboard compares every cycle of each word, from the first half of bit 1 to the first idle cycle after the gap. A bit-order or half-word mapping error shows up as a wrong HI/LO state at a known cycle. A late first bit or an off-by-one half-period shows up as the whole pattern sliding in time. The bench uses all-zero and all-ones data words, where a swapped or inverted parity sense flips bit 32. During a slow-rate word, the bench writes junk half-words, pulses start and toggles both control inputs. A design that failed to latch the controls or to block host writes would then stretch the word, restart it or corrupt the next one. The bench also checks that the gap is 4 bit times before busy drops, and compares the loopback outputs with self-test on and off.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_BITS = 2'd1,
        TX_GAP  = 2'd2
    } tx_state_e;

    localparam int WORD_BITS = 32;
    localparam int HW_BITS   = 16;
endpackage

// File: rtl/a429_tx_halfdiv.sv
module a429_tx_halfdiv #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic half_tick
);
    localparam int HALF_FAST = DIV_FAST / 2;
    localparam int HALF_SLOW = DIV_SLOW / 2;
    localparam int CW = $clog2(HALF_SLOW > HALF_FAST ? HALF_SLOW : HALF_FAST);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t q, d;
    logic [CW-1:0] lim;

    always_comb begin
        lim       = slow ? CW'(HALF_SLOW - 1) : CW'(HALF_FAST - 1);
        half_tick = run && (q.cnt == lim);
        d         = q;
        if (!run || half_tick) d.cnt = '0;
        else                   d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: the count never passes the selected half-period limit
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= lim);
endmodule

// File: rtl/a429_tx_words.sv
module a429_tx_words
    import a429_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic                 wr_hw1,
    input  logic                 wr_hw2,
    input  logic [HW_BITS-1:0]   wr_data,
    input  logic                 par_even,
    output logic [WORD_BITS-1:0] frame
);
    // data_q[n-1] holds ARINC bit n, for n = 1..31
    typedef struct packed {
        logic [WORD_BITS-2:0] data;
    } wrd_t;

    wrd_t q, d;

    always_comb begin
        d = q;
        if (!busy) begin
            if (wr_hw1) begin
                for (int k = 0; k < 8; k++) d.data[k]     = wr_data[7-k];
                for (int j = 0; j < 5; j++) d.data[8+j]   = wr_data[11+j];
                d.data[29] = wr_data[9];
                d.data[30] = wr_data[10];
            end
            if (wr_hw2) begin
                for (int i = 0; i < HW_BITS; i++) d.data[13+i] = wr_data[i];
            end
        end
        frame = {(par_even ? ^q.data : ~^q.data), q.data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: stored data cannot move while a word is in flight
    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(q.data));
endmodule

// File: rtl/a429_tx_serial.sv
module a429_tx_serial
    import a429_tx_pkg::*;
#(
    parameter int GAP_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 slow_in,
    input  logic [WORD_BITS-1:0] frame,
    input  logic                 half_tick,
    output logic                 busy,
    output logic                 slow,
    output logic                 hi,
    output logic                 lo
);
    localparam int GAP_HALVES = 2 * GAP_BITS;
    localparam int IDX_MAX    = GAP_HALVES > WORD_BITS ? GAP_HALVES : WORD_BITS;
    localparam int IW         = $clog2(IDX_MAX + 1);

    typedef struct packed {
        tx_state_e            st;
        logic                 half;
        logic [IW-1:0]        idx;
        logic [WORD_BITS-1:0] sh;
        logic                 hi;
        logic                 lo;
        logic                 slow;
    } ser_t;

    ser_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (start) begin
                    d.st   = TX_BITS;
                    d.half = 1'b0;
                    d.idx  = '0;
                    d.sh   = frame;
                    d.hi   = frame[0];
                    d.lo   = !frame[0];
                    d.slow = slow_in;
                end
            end
            TX_BITS: begin
                if (half_tick) begin
                    if (!q.half) begin
                        d.half = 1'b1;
                        d.hi   = 1'b0;
                        d.lo   = 1'b0;
                    end else begin
                        d.half = 1'b0;
                        if (q.idx == IW'(WORD_BITS - 1)) begin
                            d.st  = TX_GAP;
                            d.idx = '0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                            d.sh  = q.sh >> 1;
                            d.hi  = q.sh[1];
                            d.lo  = !q.sh[1];
                        end
                    end
                end
            end
            TX_GAP: begin
                if (half_tick) begin
                    if (q.idx == IW'(GAP_HALVES - 1)) begin
                        d.st  = TX_IDLE;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: TX_IDLE, default: '0};
        else        q <= d;
    end

    assign busy = (q.st != TX_IDLE);
    assign slow = q.slow;
    assign hi   = q.hi;
    assign lo   = q.lo;

    // R9: never both drive enables
    p_no_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));
    // R5: line is NULL whenever idle
    p_null_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!hi && !lo));
    // R5: busy only rises after a start pulse
    p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R1: rate held while busy
    p_rate_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(slow));
endmodule

// File: rtl/a429_tx_top.sv
module a429_tx_top
    import a429_tx_pkg::*;
#(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rate_slow,
    input  logic         par_even,
    input  logic         self_test,
    input  logic         wr_hw1,
    input  logic         wr_hw2,
    input  logic [15:0]  wr_data,
    input  logic         start,
    output logic         line_hi,
    output logic         line_lo,
    output logic         busy,
    output logic         lb_hi,
    output logic         lb_lo
);
    logic [WORD_BITS-1:0] frame;
    logic                 half_tick;
    logic                 slow_q;

    a429_tx_words u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .wr_hw1   (wr_hw1),
        .wr_hw2   (wr_hw2),
        .wr_data  (wr_data),
        .par_even (par_even),
        .frame    (frame)
    );

    a429_tx_halfdiv #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .slow      (slow_q),
        .half_tick (half_tick)
    );

    a429_tx_serial #(.GAP_BITS(GAP_BITS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .slow_in   (rate_slow),
        .frame     (frame),
        .half_tick (half_tick),
        .busy      (busy),
        .slow      (slow_q),
        .hi        (line_hi),
        .lo        (line_lo)
    );

    assign lb_hi = self_test & line_hi;
    assign lb_lo = self_test & line_lo;

    // R7: loopback idles at NULL with self-test off
    p_lb_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !self_test |-> (!lb_hi && !lb_lo));
endmodule

// File: tb/sim_a429_tx_top.sv
module sim_a429_tx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_slow = 1'b0, par_even = 1'b0, self_test = 1'b0;
    logic        wr_hw1 = 1'b0, wr_hw2 = 1'b0, start = 1'b0;
    logic [15:0] wr_data = '0;
    logic        line_hi, line_lo, busy, lb_hi, lb_lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [32:1] f;
        bit          slow;
    } exp_t;
    exp_t sb[$];

    logic [15:0] m_h1 = '0, m_h2 = '0;

    always #2 clk = ~clk;

    a429_tx_top u0 (
        .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .par_even(par_even),
        .self_test(self_test), .wr_hw1(wr_hw1), .wr_hw2(wr_hw2),
        .wr_data(wr_data), .start(start), .line_hi(line_hi),
        .line_lo(line_lo), .busy(busy), .lb_hi(lb_hi), .lb_lo(lb_lo)
    );

    function automatic logic [32:1] build(logic [15:0] h1, logic [15:0] h2, bit ev);
        logic [32:1] w;
        int ones = 0;
        w = '0;
        for (int n = 1; n <= 8; n++)   w[n] = h1[8-n];
        for (int n = 9; n <= 13; n++)  w[n] = h1[n+2];
        for (int n = 14; n <= 29; n++) w[n] = h2[n-14];
        w[30] = h1[9];
        w[31] = h1[10];
        for (int n = 1; n <= 31; n++)  ones += int'(w[n]);
        w[32] = ev ? ((ones % 2) == 1) : ((ones % 2) == 0);
        return w;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // R3: host writes, mirrored into the bench model
    task automatic write_hw(logic [15:0] h1, logic [15:0] h2);
        @(negedge clk); wr_hw1 = 1'b1; wr_data = h1;
        @(negedge clk); wr_hw1 = 1'b0; wr_hw2 = 1'b1; wr_data = h2;
        @(negedge clk); wr_hw2 = 1'b0; wr_data = '0;
        m_h1 = h1; m_h2 = h2;
    endtask

    task automatic send(bit slow, bit ev, bit st);
        exp_t e;
        @(negedge clk);
        rate_slow = slow; par_even = ev; self_test = st; start = 1'b1;
        e.f = build(m_h1, m_h2, ev); e.slow = slow;
        sb.push_back(e);
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops one expected word per busy rise, checks every cycle
    initial begin
        exp_t e;
        int h, tot;
        bit ehi, elo;
        forever begin
            @(negedge clk);
            if (rst_n && busy) begin
                if (sb.size() == 0) begin
                    chk(0, "R6", "unexpected word", 1, 0);
                    while (busy) @(negedge clk);
                end else begin
                    e = sb.pop_front();
                    h = e.slow ? 40 : 5;
                    tot = 72 * h;
                    for (int k = 0; k <= tot; k++) begin
                        if (k > 0) @(negedge clk);
                        ehi = 0; elo = 0;
                        if (k < 64 * h && ((k / h) % 2) == 0) begin
                            ehi = e.f[k / (2 * h) + 1];
                            elo = !ehi;
                        end
                        chk(line_hi == ehi, "R2", "line_hi", int'(line_hi), int'(ehi));
                        chk(line_lo == elo, "R2", "line_lo", int'(line_lo), int'(elo));
                        chk(busy == (k < tot), "R5", "busy", int'(busy), int'(k < tot));
                        chk(lb_hi == (self_test & ehi) && lb_lo == (self_test & elo),
                            "R7", "loopback", int'({lb_hi, lb_lo}),
                            int'({self_test & ehi, self_test & elo}));
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "WATCHDOG", "timeout", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(!busy && !line_hi && !line_lo, "R8", "outputs after reset",
            int'({busy, line_hi, line_lo}), 0);
        chk(!lb_hi && !lb_lo, "R8", "loopback after reset", int'({lb_hi, lb_lo}), 0);
        send(0, 0, 0);                     // R8: all-zero stored data, odd parity
        wait_idle();
        // R3 R2: mixed pattern, fast rate, odd parity
        write_hw(16'hA5C3, 16'h1E69);
        send(0, 0, 0);
        wait_idle();
        // R4: even parity, self-test on (R7)
        write_hw(16'h5B7E, 16'hF00D);
        send(0, 1, 1);
        wait_idle();
        // R4: all ones data, both senses
        write_hw(16'hFFFF, 16'hFFFF);
        send(0, 0, 0);
        wait_idle();
        send(0, 1, 0);
        wait_idle();
        // R1: slow rate
        write_hw(16'h0180, 16'h8001);
        send(1, 0, 1);
        // R6 R1 R4: disturbances mid-word
        repeat (100) @(negedge clk);
        wr_hw1 = 1'b1; wr_data = 16'h1234;
        @(negedge clk); wr_hw1 = 1'b0; wr_hw2 = 1'b1; wr_data = 16'h4321;
        @(negedge clk); wr_hw2 = 1'b0; start = 1'b1; rate_slow = 1'b0; par_even = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_idle();
        // R6: next word still carries old data
        send(0, 0, 0);
        wait_idle();
        chk(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule